// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Controller

This block links a local processor and a remote processor through sixteen independent doorbell channels in each direction. Every channel is a single flag bit. One side rings a channel by writing a one to that bit; the other side sees the flag, may mask it, and acknowledges it by clearing it. The message behind a doorbell is held in external memory. The block carries only the notification, so no message register is decoded.

The local processor reaches the block through a 32-bit peripheral bus with APB-style setup and access phases. Its register map holds two mirrored groups. The inbound group holds flags that the remote side raises and the local side clears. The outbound group holds flags that the local side raises and the remote side clears. The remote processor drives two pulse vectors. One sets inbound flags and the other clears outbound flags. Each side receives one level interrupt, formed from the unmasked flags of the direction aimed at it.

Word offsets are fixed:
- Inbound group: clear 0x24, mask 0x28, raw status 0x2C, masked status 0x30.
- Outbound group: ring 0x40, mask 0x48, raw status 0x4C, masked status 0x50.
- Offset 0x00 is a control slot that reads zero in doorbell operation.

Top module: `dbell_mbox`

## Requirements
- R1: After reset, all inbound and outbound flags are 0, both mask registers read 0x0000FFFF, and both interrupt outputs are low.
- R2: A bus write to offset 0x40 sets every outbound flag whose data bit (15:0) is 1 and leaves flags at 0 bits unchanged. Offset 0x4C returns the outbound flags in bits 15:0.
- R3: A bus write to offset 0x24 clears every inbound flag whose data bit is 1, and 0 bits have no effect. Offset 0x2C returns the inbound flags.
- R4: When a set and a clear of the same flag arrive in the same cycle, the flag ends up set. This holds in both directions.
- R5: Offsets 0x28 and 0x48 are read/write masks over bits 15:0, and bits 31:16 read 0. Offsets 0x30 and 0x50 return flags AND NOT mask for their group.
- R6: irq_local is high exactly when some inbound flag is set with its mask bit clear. irq_remote is the same for outbound flags. Each follows its flags in the cycle after they change.
- R7: A bit set in rmt_set sets that inbound flag. A bit set in rmt_clr clears that outbound flag.
- R8: Every offset other than 0x28, 0x2C, 0x30, 0x48, 0x4C and 0x50 reads 0, including 0x00, 0x24 and 0x40. Writes to offsets other than 0x24, 0x28, 0x40 and 0x48 change no state.
- R9: Writes to the four status offsets change neither flags nor masks.
- R10: Every access completes with pready high, and pslverr is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Access complete |
| pslverr | output | 1 | Error response, always 0 |
| rmt_set | input | 16 | Remote pulses that set inbound flags |
| rmt_clr | input | 16 | Remote pulses that clear outbound flags |
| irq_local | output | 1 | Interrupt toward the local processor |
| irq_remote | output | 1 | Interrupt toward the remote processor |

## Verification
Each of the sixteen channels is rung on its own with a one-hot word. This distinguishes a correct bit mapping from a shifted, swapped or shared one, and shows that zero bits leave earlier flags alone. Mask patterns of all-ones, all-zeros and alternating bits separate the raw status from the masked status and from the interrupt line. Same-cycle set/clear collisions test which one takes priority. Finally, a sweep writes all-ones to every unmapped and status word address, then reads every address back, which exposes any decode alias or any write that leaks into state.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned NCH = 16;
  localparam int unsigned DW  = 32;

  localparam logic [11:0] OFF_IN_CLR  = 12'h024;
  localparam logic [11:0] OFF_IN_MSK  = 12'h028;
  localparam logic [11:0] OFF_IN_STS  = 12'h02C;
  localparam logic [11:0] OFF_IN_MST  = 12'h030;
  localparam logic [11:0] OFF_OUT_GEN = 12'h040;
  localparam logic [11:0] OFF_OUT_MSK = 12'h048;
  localparam logic [11:0] OFF_OUT_STS = 12'h04C;
  localparam logic [11:0] OFF_OUT_MST = 12'h050;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IN_CLR,
    SEL_IN_MSK,
    SEL_IN_STS,
    SEL_IN_MST,
    SEL_OUT_GEN,
    SEL_OUT_MSK,
    SEL_OUT_STS,
    SEL_OUT_MST
  } reg_sel_e;
endpackage

// File: rtl/dbm_flag_bank.sv
module dbm_flag_bank #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_wdata,
  output logic [NCH-1:0] flag,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] masked,
  output logic           irq
);
  logic [NCH-1:0] flag_nxt;
  logic [NCH-1:0] mask_nxt;
  logic           flag_en;

  // set takes priority over clear so that no doorbell is lost
  always_comb begin
    flag_en  = |set_vec || |clr_vec;
    flag_nxt = (flag & ~clr_vec) | set_vec;
    mask_nxt = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
    end else if (flag_en) begin
      flag <= flag_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (mask_we) begin
      mask <= mask_nxt;
    end
  end

  assign masked = flag & ~mask;
  assign irq    = |masked;

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flag & $past(set_vec)) == $past(set_vec)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((flag & $past(clr_vec & ~set_vec)) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(flag));

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0));
endmodule

// File: rtl/dbm_regif.sv
module dbm_regif
  import dbm_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned NCH = 16
) (
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  input  logic [NCH-1:0] in_flag,
  input  logic [NCH-1:0] in_mask,
  input  logic [NCH-1:0] in_masked,
  input  logic [NCH-1:0] out_flag,
  input  logic [NCH-1:0] out_mask,
  input  logic [NCH-1:0] out_masked,
  output logic [NCH-1:0] in_clr_vec,
  output logic           in_mask_we,
  output logic [NCH-1:0] out_gen_vec,
  output logic           out_mask_we,
  output logic [NCH-1:0] wdata_ch
);
  localparam int unsigned WAW = AW - 2;

  reg_sel_e       sel;
  logic           wr_acc;
  logic [NCH-1:0] rd_ch;
  logic           unused_bits;

  assign unused_bits = ^{pwdata[DW-1:NCH], paddr[1:0]};

  always_comb begin
    unique case (paddr[AW-1:2])
      WAW'(OFF_IN_CLR  >> 2): sel = SEL_IN_CLR;
      WAW'(OFF_IN_MSK  >> 2): sel = SEL_IN_MSK;
      WAW'(OFF_IN_STS  >> 2): sel = SEL_IN_STS;
      WAW'(OFF_IN_MST  >> 2): sel = SEL_IN_MST;
      WAW'(OFF_OUT_GEN >> 2): sel = SEL_OUT_GEN;
      WAW'(OFF_OUT_MSK >> 2): sel = SEL_OUT_MSK;
      WAW'(OFF_OUT_STS >> 2): sel = SEL_OUT_STS;
      WAW'(OFF_OUT_MST >> 2): sel = SEL_OUT_MST;
      default:                sel = SEL_NONE;
    endcase
  end

  always_comb begin
    wr_acc      = psel && penable && pwrite;
    wdata_ch    = pwdata[NCH-1:0];
    in_clr_vec  = (wr_acc && sel == SEL_IN_CLR)  ? wdata_ch : '0;
    out_gen_vec = (wr_acc && sel == SEL_OUT_GEN) ? wdata_ch : '0;
    in_mask_we  = wr_acc && sel == SEL_IN_MSK;
    out_mask_we = wr_acc && sel == SEL_OUT_MSK;
  end

  always_comb begin
    case (sel)
      SEL_IN_MSK:  rd_ch = in_mask;
      SEL_IN_STS:  rd_ch = in_flag;
      SEL_IN_MST:  rd_ch = in_masked;
      SEL_OUT_MSK: rd_ch = out_mask;
      SEL_OUT_STS: rd_ch = out_flag;
      SEL_OUT_MST: rd_ch = out_masked;
      default:     rd_ch = '0;
    endcase
    prdata = psel ? {{(DW-NCH){1'b0}}, rd_ch} : '0;
  end

  p_rd_unmapped_r8: assert property (@(posedge penable)
    (psel && sel == SEL_NONE) |-> (prdata == '0));
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
  import dbm_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           pready,
  output logic           pslverr,
  input  logic [15:0]    rmt_set,
  input  logic [15:0]    rmt_clr,
  output logic           irq_local,
  output logic           irq_remote
);
  logic [NCH-1:0] in_flag, in_mask, in_masked, in_clr_vec;
  logic [NCH-1:0] out_flag, out_mask, out_masked, out_gen_vec;
  logic [NCH-1:0] wdata_ch;
  logic           in_mask_we, out_mask_we;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  dbm_regif #(.AW(AW), .NCH(NCH)) u_regif (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .in_flag(in_flag), .in_mask(in_mask), .in_masked(in_masked),
    .out_flag(out_flag), .out_mask(out_mask), .out_masked(out_masked),
    .in_clr_vec(in_clr_vec), .in_mask_we(in_mask_we),
    .out_gen_vec(out_gen_vec), .out_mask_we(out_mask_we),
    .wdata_ch(wdata_ch)
  );

  // inbound: remote rings, local clears
  dbm_flag_bank #(.NCH(NCH)) u_inbound (
    .clk(clk), .rst_n(rst_n),
    .set_vec(rmt_set), .clr_vec(in_clr_vec),
    .mask_we(in_mask_we), .mask_wdata(wdata_ch),
    .flag(in_flag), .mask(in_mask), .masked(in_masked), .irq(irq_local)
  );

  // outbound: local rings, remote clears
  dbm_flag_bank #(.NCH(NCH)) u_outbound (
    .clk(clk), .rst_n(rst_n),
    .set_vec(out_gen_vec), .clr_vec(rmt_clr),
    .mask_we(out_mask_we), .mask_wdata(wdata_ch),
    .flag(out_flag), .mask(out_mask), .masked(out_masked), .irq(irq_remote)
  );

  p_gen_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr == OFF_OUT_GEN)
      |=> ((out_flag & $past(pwdata[NCH-1:0])) == $past(pwdata[NCH-1:0])));

  p_rmt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rmt_set) |=> ((in_flag & $past(rmt_set)) == $past(rmt_set)));

  p_status_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && (paddr == OFF_IN_STS || paddr == OFF_IN_MST)
     && rmt_set == '0) |=> ($stable(in_flag) && $stable(in_mask)));

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mask == '1) |-> !irq_local);
endmodule

// File: tb/dbell_mbox_bench.sv
module dbell_mbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [15:0] rmt_set = '0, rmt_clr = '0;
  logic        irq_local, irq_remote;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_in = '0, m_inm = '1, m_out = '0, m_outm = '1;

  always #2 clk = ~clk;  // 250 MHz

  dbell_mbox u_dbell_mbox (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rmt_set(rmt_set), .rmt_clr(rmt_clr),
    .irq_local(irq_local), .irq_remote(irq_remote)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h028: exp_rd = {16'h0, m_inm};
      12'h02C: exp_rd = {16'h0, m_in};
      12'h030: exp_rd = {16'h0, m_in & ~m_inm};
      12'h048: exp_rd = {16'h0, m_outm};
      12'h04C: exp_rd = {16'h0, m_out};
      12'h050: exp_rd = {16'h0, m_out & ~m_outm};
      default: exp_rd = '0;
    endcase
  endfunction

  // one bus write; rs/rc drive the remote ports during the access cycle
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d,
                        input logic [15:0] rs, input logic [15:0] rc);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; rmt_set = rs; rmt_clr = rc;
    #1 check("R10 pready", {31'h0, pready}, 32'h1);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; rmt_set = '0; rmt_clr = '0;
    case (a)
      12'h024: m_in = (m_in & ~d[15:0]) | rs;
      12'h040: m_out = (m_out & ~rc) | d[15:0];
      12'h028: m_inm = d[15:0];
      12'h048: m_outm = d[15:0];
      default: ;
    endcase
    if (a != 12'h024) m_in = m_in | rs;
    if (a != 12'h040) m_out = m_out & ~rc;
  endtask

  task automatic bus_rd(input logic [11:0] a, input string req);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 check(req, prdata, exp_rd(a));
    check("R10 pslverr", {31'h0, pslverr}, 32'h0);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rpulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    rmt_set = s; rmt_clr = c;
    @(negedge clk);
    rmt_set = '0; rmt_clr = '0;
    m_in = m_in | s;
    m_out = m_out & ~c;
  endtask

  task automatic chk_irq(input string req);
    #1;
    check({req, " irq_local"}, {31'h0, irq_local}, {31'h0, |(m_in & ~m_inm)});
    check({req, " irq_remote"}, {31'h0, irq_remote}, {31'h0, |(m_out & ~m_outm)});
  endtask

  task automatic rd_all(input string req);
    bus_rd(12'h028, req); bus_rd(12'h02C, req); bus_rd(12'h030, req);
    bus_rd(12'h048, req); bus_rd(12'h04C, req); bus_rd(12'h050, req);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_irq("R1");
    rd_all("R1 reset");

    // R2 ring each outbound channel one-hot, check accumulation
    for (int n = 0; n < 16; n++) begin
      bus_wr(12'h040, 32'hFFFF0000 | (32'h1 << n), '0, '0);
      bus_rd(12'h04C, "R2 one-hot ring");
      chk_irq("R6 masked ring");
    end
    // R7 remote clears outbound one at a time, R6 irq follows
    bus_wr(12'h048, 32'h0, '0, '0);
    for (int n = 0; n < 16; n++) begin
      rpulse('0, 16'h1 << n);
      chk_irq("R6/R7 remote clear");
      bus_rd(12'h050, "R7 outbound after remote clear");
    end

    // R7 remote sets inbound one-hot; R3 local clears
    for (int n = 0; n < 16; n++) begin
      rpulse(16'h1 << n, '0);
      bus_rd(12'h02C, "R7 remote set");
    end
    chk_irq("R1 mask holds irq low");
    foreach (m_in[k]) begin
      logic [15:0] pat;
      pat = (k % 2) ? 16'hAAAA : 16'h5555;
      bus_wr(12'h028, {16'hFFFF, pat}, '0, '0);
      chk_irq("R6 alternating mask");
      rd_all("R5 alternating mask");
      if (k >= 1) break;
    end
    bus_wr(12'h024, 32'h0000_00F0, '0, '0);
    bus_rd(12'h02C, "R3 partial clear");
    bus_wr(12'h024, 32'h0, '0, '0);
    bus_rd(12'h02C, "R3 zero clear no effect");

    // R4 collisions in both directions
    bus_wr(12'h024, 32'h0000_0101, 16'h0101, '0);
    bus_rd(12'h02C, "R4 set wins inbound");
    bus_wr(12'h040, 32'h0000_8001, '0, 16'h8001);
    bus_rd(12'h04C, "R4 set wins outbound");
    chk_irq("R4/R6");

    // R8/R9 sweep: all-ones into every non-acting address
    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      a = 12'(w << 2);
      if (a != 12'h024 && a != 12'h028 && a != 12'h040 && a != 12'h048)
        bus_wr(a, 32'hFFFF_FFFF, '0, '0);
    end
    rd_all("R8/R9 state after sweep");
    for (int w = 0; w < 1024; w++) bus_rd(12'(w << 2), "R8 read map");
    chk_irq("R6 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule